// File: doc/BRIEF.md
# Receive Packet Address Filter

This block sits at the head of a receive path and makes one decision per packet: keep it or throw it away. When the first data word of a new packet is presented with its strobe, the filter examines two receive-status flags (collision seen by the receiver, and a packet that ended off a byte boundary) and the destination byte carried in the upper bits of that word. It compares the destination byte with a programmable station address. A station address of zero makes the filter promiscuous. A destination of zero is treated as a broadcast.

An accepted packet raises a level `accept` that the payload logic uses until the packet's last word. A rejected packet produces a single-cycle `purge` pulse. When the address is accepted but the host buffer has a word count of zero, nothing is stored and a single-cycle `count_zero` pulse reports the completion instead. The block also holds a flag that the transmit side arms while it waits out a backoff. Accepting an address clears that flag, so the transmitter can see that input arrived during its wait.

The control is a small Moore machine with four states. `ST_IDLE` waits for a first word. `ST_PASS` holds acceptance until end of packet. `ST_DROP` is the one-cycle purge state. `ST_EMPTY` is the one-cycle count-zero state. The transitions are as follows. Idle goes to drop on bad status or an address miss. Idle goes to empty on an address hit with a zero count. Idle goes to pass on an address hit with a nonzero count. Pass returns to idle on `eop`. Drop and empty always return to idle on the next cycle.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, `accept`, `purge` and `count_zero` are low and `backoff_flag` is low.
- R2: If `rx_jam` or `rx_misalign` is high when `first_valid` is sampled in the idle state, `purge` pulses and `accept` stays low, whatever the address.
- R3: With `host_addr` equal to zero, every packet with clean status is accepted.
- R4: A packet whose destination byte (bits WORD_W-1 down to WORD_W-ADDR_W of `first_word`) equals `host_addr` is accepted.
- R5: A packet whose destination byte is zero is accepted as broadcast.
- R6: With clean status, a nonzero `host_addr` and a destination byte that is neither zero nor equal to `host_addr`, the packet is purged.
- R7: `accept` stays high from the decision until the clock edge that samples `eop`, and is low after that edge.
- R8: `purge` and `count_zero` are one-cycle pulses, and at most one of `accept`, `purge` and `count_zero` is high at any time.
- R9: If the address is accepted but `buf_count` is zero, `count_zero` pulses and `accept` stays low.
- R10: `backoff_arm` sets `backoff_flag`. An accepted address (including the count-zero case) clears it at the decision edge, and the clear wins over a simultaneous arm.
- R11: `first_valid` raised while a packet is being accepted has no effect; `accept` stays high until `eop`.
- R12: The decision outputs change at the first clock edge that samples `first_valid` high in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Station address; zero selects promiscuous mode |
| buf_count | input | CNT_W | Host buffer word count for the current packet |
| rx_jam | input | 1 | Receiver saw a collision on this packet |
| rx_misalign | input | 1 | Packet ended off a byte boundary |
| first_word | input | WORD_W | First data word of the packet |
| first_valid | input | 1 | Strobe marking `first_word` as the start of a packet |
| eop | input | 1 | Last word of the accepted packet |
| backoff_arm | input | 1 | Transmit side enters its backoff wait |
| accept | output | 1 | Packet accepted; held until end of packet |
| purge | output | 1 | One-cycle pulse: discard the packet |
| count_zero | output | 1 | One-cycle pulse: address accepted, zero-length buffer |
| backoff_flag | output | 1 | High while backoff waits and no packet has been accepted |

## Verification
The bench builds the filter with a 16-bit word and an 8-bit address, as in the defaults, but with `CNT_W` reduced to 4. That way random buffer counts hit zero about once in sixteen packets, and the count-zero path shows up in the random run as well as in the directed case. The destination bytes are drawn with bias toward the station address and zero. This brings unicast hits, broadcasts, misses and promiscuous packets all within reach of a short run. Arm pulses are interleaved so that the flag is seen both cleared by acceptance and left set by purged packets.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_DROP  = 2'd2,
        ST_EMPTY = 2'd3
    } rxf_state_e;
endpackage

// File: rtl/rxf_dest_match.sv
module rxf_dest_match #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] first_word,
    input  logic              rx_jam,
    input  logic              rx_misalign,
    output logic              bad_status,
    output logic              addr_hit
);
    localparam int DEST_LSB = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] dest;
    logic promisc, unicast, bcast;

    always_comb begin
        dest       = first_word[WORD_W-1:DEST_LSB];
        promisc    = (host_addr == '0);
        unicast    = (dest == host_addr);
        bcast      = (dest == '0);
        bad_status = rx_jam | rx_misalign;
        addr_hit   = promisc | unicast | bcast;
    end
endmodule

// File: rtl/rxf_arrive_flag.sv
module rxf_arrive_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (clr) flag <= 1'b0;
        else if (arm) flag <= 1'b1;
    end

    // R10: an arm with no simultaneous clear sets the flag
    a_r10_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clr) |=> flag);
    // R10: a clear wins and drops the flag
    a_r10_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic              rx_jam,
    input  logic              rx_misalign,
    input  logic [WORD_W-1:0] first_word,
    input  logic              first_valid,
    input  logic              eop,
    input  logic              backoff_arm,
    output logic              accept,
    output logic              purge,
    output logic              count_zero,
    output logic              backoff_flag
);
    import rxf_pkg::*;

    rxf_state_e state_q, state_d;
    logic bad_status, addr_hit, start, take_clear;

    rxf_dest_match #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_match (
        .host_addr  (host_addr),
        .first_word (first_word),
        .rx_jam     (rx_jam),
        .rx_misalign(rx_misalign),
        .bad_status (bad_status),
        .addr_hit   (addr_hit)
    );

    assign start      = (state_q == ST_IDLE) && first_valid;
    assign take_clear = start && !bad_status && addr_hit;

    rxf_arrive_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (backoff_arm),
        .clr  (take_clear),
        .flag (backoff_flag)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (first_valid) begin
                    if (bad_status || !addr_hit) state_d = ST_DROP;
                    else if (buf_count == '0)    state_d = ST_EMPTY;
                    else                         state_d = ST_PASS;
                end
            end
            ST_PASS:  if (eop) state_d = ST_IDLE;
            ST_DROP:  state_d = ST_IDLE;
            ST_EMPTY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept     = 1'b0;
        purge      = 1'b0;
        count_zero = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_PASS:  accept = 1'b1;
            ST_DROP:  purge = 1'b1;
            ST_EMPTY: count_zero = 1'b1;
            default:  ;
        endcase
    end

    // R2: bad status at packet start forces a purge
    a_r2_status_purge: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (rx_jam || rx_misalign)) |=> (purge && !accept));
    // R8: single-cycle pulses and exclusive outputs
    a_r8_purge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> !purge);
    a_r8_zero_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        count_zero |=> !count_zero);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept, purge, count_zero}));
    // R7: accept holds until eop is sampled, then falls
    a_r7_accept_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !eop) |=> accept);
    a_r7_accept_end: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && eop) |=> !accept);
    // R9: a hit with a zero count reports count_zero
    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (take_clear && buf_count == '0) |=> (count_zero && !accept));
endmodule

// File: tb/tb_rxf_addr_filter.sv
module tb_rxf_addr_filter;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [CNT_W-1:0]  buf_count = '0;
    logic              rx_jam = 1'b0, rx_misalign = 1'b0;
    logic [WORD_W-1:0] first_word = '0;
    logic              first_valid = 1'b0, eop = 1'b0, backoff_arm = 1'b0;
    logic              accept, purge, count_zero, backoff_flag;

    int checks = 0;
    int failures = 0;
    logic exp_flag = 1'b0;

    always #4 clk = ~clk;

    rxf_addr_filter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .buf_count(buf_count),
        .rx_jam(rx_jam), .rx_misalign(rx_misalign), .first_word(first_word),
        .first_valid(first_valid), .eop(eop), .backoff_arm(backoff_arm),
        .accept(accept), .purge(purge), .count_zero(count_zero),
        .backoff_flag(backoff_flag)
    );

    // 0 = accept, 1 = purge, 2 = count zero
    function automatic int exp_kind(logic [ADDR_W-1:0] h, logic [WORD_W-1:0] w,
                                    logic j, logic m, logic [CNT_W-1:0] c);
        logic [ADDR_W-1:0] d;
        d = w[WORD_W-1:WORD_W-ADDR_W];
        if (j || m) return 1;
        if (!(h == '0 || d == h || d == '0)) return 1;
        if (c == '0) return 2;
        return 0;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {acc,pur,zero,flag} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic arm_pulse();
        @(negedge clk); backoff_arm = 1'b1;
        @(posedge clk); #1; exp_flag = 1'b1;
        @(negedge clk); backoff_arm = 1'b0;
        check("R10 arm", {accept, purge, count_zero, backoff_flag}, {3'b000, exp_flag});
    endtask

    task automatic packet(string req, logic [ADDR_W-1:0] h, logic [WORD_W-1:0] w,
                          logic j, logic m, logic [CNT_W-1:0] c, int len,
                          logic arm_same, logic refire);
        int k;
        logic [3:0] e;
        k = exp_kind(h, w, j, m, c);
        @(negedge clk);
        host_addr = h; first_word = w; rx_jam = j; rx_misalign = m;
        buf_count = c; first_valid = 1'b1; backoff_arm = arm_same;
        @(posedge clk); #1;
        if (k != 1) exp_flag = 1'b0;
        else if (arm_same) exp_flag = 1'b1;
        e = (k == 0) ? 4'b1000 : (k == 1) ? 4'b0100 : 4'b0010;
        e[0] = exp_flag;
        check({req, " R12 decision"}, {accept, purge, count_zero, backoff_flag}, e);
        @(negedge clk); first_valid = 1'b0; backoff_arm = 1'b0;
        if (k == 0) begin
            for (int i = 0; i < len; i++) begin
                if (refire && i == 0) first_valid = 1'b1;
                @(posedge clk); #1;
                check(refire ? "R11 refire ignored" : "R7 hold",
                      {accept, purge, count_zero, backoff_flag}, {3'b100, exp_flag});
                @(negedge clk); first_valid = 1'b0;
            end
            eop = 1'b1;
            @(posedge clk); #1;
            check("R7 end", {accept, purge, count_zero, backoff_flag}, {3'b000, exp_flag});
            @(negedge clk); eop = 1'b0;
        end else begin
            @(posedge clk); #1;
            check("R8 pulse", {accept, purge, count_zero, backoff_flag}, {3'b000, exp_flag});
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {accept, purge, count_zero, backoff_flag}, 4'b0000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after", {accept, purge, count_zero, backoff_flag}, 4'b0000);

        arm_pulse();
        packet("R2 jam", 8'h12, 16'h1234, 1'b1, 1'b0, 4'd5, 0, 1'b0, 1'b0);
        packet("R2 misalign", 8'h12, 16'h0000, 1'b0, 1'b1, 4'd5, 0, 1'b0, 1'b0);
        packet("R6 miss", 8'h12, 16'h3456, 1'b0, 1'b0, 4'd5, 0, 1'b0, 1'b0);
        packet("R4 unicast", 8'h12, 16'h12AB, 1'b0, 1'b0, 4'd5, 3, 1'b0, 1'b0);
        arm_pulse();
        packet("R5 broadcast", 8'h12, 16'h00FF, 1'b0, 1'b0, 4'd2, 2, 1'b0, 1'b0);
        packet("R3 promiscuous", 8'h00, 16'hC3C3, 1'b0, 1'b0, 4'd7, 1, 1'b0, 1'b0);
        packet("R9 zero count", 8'h12, 16'h1200, 1'b0, 1'b0, 4'd0, 0, 1'b1, 1'b0);
        packet("R10 clear wins", 8'h12, 16'h1201, 1'b0, 1'b0, 4'd3, 1, 1'b1, 1'b0);
        packet("R11 refire", 8'h12, 16'h1202, 1'b0, 1'b0, 4'd3, 2, 1'b0, 1'b1);
        packet("R10 purge keeps arm", 8'h12, 16'h7777, 1'b0, 1'b0, 4'd3, 0, 1'b1, 1'b0);

        for (int n = 0; n < 60; n++) begin
            logic [ADDR_W-1:0] h, d;
            logic [WORD_W-1:0] w;
            int sel;
            h = ($urandom % 6 == 0) ? '0 : ADDR_W'($urandom);
            sel = $urandom % 4;
            d = (sel == 0) ? h : (sel == 1) ? '0 : ADDR_W'($urandom);
            w = {d, ADDR_W'($urandom)};
            if ($urandom % 3 == 0) arm_pulse();
            packet("R2-R6 random", h, w, ($urandom % 8 == 0), ($urandom % 8 == 0),
                   CNT_W'($urandom), $urandom % 4, ($urandom % 5 == 0), 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule